// File: doc/BRIEF.md
# DRAM Bank Timing Constraint Tracker

This block sits beside a DRAM command scheduler and keeps one timing record per bank of every rank. Each issued command carries a type (activate, read, write, precharge), a rank, a bank group and a bank within that group. From this stream the block works out, for each bank, the earliest cycle at which an activate, a column command and a precharge may next be issued. It publishes three registered per-bank "allowed" vectors that the scheduler can poll every cycle.

Spacing between activates and between column commands depends on whether the other bank shares the bank group of the command just issued. A shared group gets the long delay and any other group in the same rank gets the short delay. Precharge permission for a bank combines three limits: the row-active time after an activate, the read-to-precharge time after a read, and the write-data-plus-recovery time after a write. Each record is a stored cycle count that is compared against a free-running counter. An update only ever moves a stored count later. If a command is issued while its own constraint is still open, the block raises a sticky error flag and captures the type of the first offending command.

Top module: `dbt_bank_timing_tracker`

## Requirements
- R1: After reset every bit of the three allowed vectors is 1, the violation flag is 0 and the captured type is 0.
- R2: An activate to a bank clears that bank's column-allowed bit until T_RCD cycles after the activate. It clears that bank's precharge-allowed bit until T_RAS cycles after the activate.
- R3: An activate delays the activate-allowed bit of other banks in the same rank. Banks in the same group wait T_RRD_L cycles and banks in other groups wait T_RRD_S cycles. The activated bank itself waits T_RAS+T_RP cycles. Banks of other ranks are not affected.
- R4: A read or write delays the column-allowed bit of every bank in the same rank. Banks in the same group wait T_CCD_L cycles and banks in other groups wait T_CCD_S cycles. Other ranks are not affected.
- R5: A read to a bank keeps that bank's precharge-allowed bit at 0 until T_RTP cycles after the read.
- R6: A write to a bank keeps that bank's precharge-allowed bit at 0 until T_WL+T_BURST+T_WR cycles after the write.
- R7: A precharge to a bank keeps that bank's activate-allowed bit at 0 until T_RP cycles after the precharge.
- R8: Each update moves a bank's earliest time later or leaves it unchanged. A later command with a shorter delay never brings an allowed bit back early.
- R9: When BANK_GROUPS is 1, every bank of a rank is spaced by the short delays T_RRD_S and T_CCD_S, and the group field is ignored.
- R10: A command issued while its allowed bit is 0 sets the violation flag in the next cycle. The flag stays set until reset. The captured type holds the encoding of the first offending command (activate 0, read 1, write 2, precharge 3). The offending command still updates the timing records.
- R11: A bank's bit position in the allowed vectors is (rank*BANK_GROUPS + group)*BANKS_PER_GROUP + bank. A bit reads 1 in any cycle where a command of that kind to that bank would be legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_type | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| cmd_rank | input | RANK_W | Target rank |
| cmd_group | input | GRP_W | Target bank group (ignored when BANK_GROUPS is 1) |
| cmd_bank | input | BANK_W | Bank within the group |
| act_ok | output | NUM_BANKS | Per-bank activate allowed this cycle |
| col_ok | output | NUM_BANKS | Per-bank read/write allowed this cycle |
| pre_ok | output | NUM_BANKS | Per-bank precharge allowed this cycle |
| viol | output | 1 | Sticky too-early command flag |
| viol_type | output | 2 | Type of the first too-early command |

## Verification
The bench builds two copies that share one command stream. One copy has two ranks, two bank groups and two banks per group. The other has two ranks, a single group and four banks, so the group-aware spacing and its flat reduction are checked side by side. Every delay is set to a few cycles, with each long delay different from its short delay and the write-recovery sum larger than the row-active time. With these values each of the three precharge limits can be made the deciding one within a handful of cycles. The same small values also let thousands of legal and illegal random commands pile overlapping constraints on one bank.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } dbt_cmd_e;

  function automatic int clog2_min1(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dbt_cycle_counter.sv
module dbt_cycle_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] now
);

  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else     now <= now + 1'b1;
  end

endmodule

// File: rtl/dbt_bank_slot.sv
module dbt_bank_slot
  import dbt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int T_RCD    = 16,
  parameter int T_RAS    = 39,
  parameter int T_RP     = 16,
  parameter int T_TRC    = 55,
  parameter int RRD_NEAR = 6,
  parameter int RRD_FAR  = 4,
  parameter int CCD_NEAR = 6,
  parameter int CCD_FAR  = 4,
  parameter int T_RTP    = 9,
  parameter int T_WRPRE  = 34
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] now,
  input  logic             hit,    // valid command to this bank's rank
  input  dbt_cmd_e         cmd,
  input  logic             near,   // command targets this bank's group
  input  logic             own,    // command targets this very bank
  output logic             act_ok,
  output logic             col_ok,
  output logic             pre_ok
);

  logic [CNT_W-1:0] act_at, col_at, pre_at;
  logic [CNT_W-1:0] act_nx, col_nx, pre_nx;
  logic [CNT_W-1:0] now_nx;

  // Earliest time only moves forward
  function automatic logic [CNT_W-1:0] later(input logic [CNT_W-1:0] cur,
                                             input logic [CNT_W-1:0] t,
                                             input int               dly);
    logic [CNT_W-1:0] cand;
    cand = t + CNT_W'(dly);
    return (cand > cur) ? cand : cur;
  endfunction

  always_comb begin
    act_nx = act_at;
    col_nx = col_at;
    pre_nx = pre_at;
    if (hit) begin
      case (cmd)
        CMD_ACT: begin
          if (own) begin
            act_nx = later(act_at, now, T_TRC);
            col_nx = later(col_at, now, T_RCD);
            pre_nx = later(pre_at, now, T_RAS);
          end else begin
            act_nx = later(act_at, now, near ? RRD_NEAR : RRD_FAR);
          end
        end
        CMD_RD, CMD_WR: begin
          col_nx = later(col_at, now, near ? CCD_NEAR : CCD_FAR);
          if (own)
            pre_nx = later(pre_at, now, (cmd == CMD_RD) ? T_RTP : T_WRPRE);
        end
        CMD_PRE: begin
          if (own) act_nx = later(act_at, now, T_RP);
        end
        default: ;
      endcase
    end
  end

  assign now_nx = now + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_at <= '0;
      col_at <= '0;
      pre_at <= '0;
      act_ok <= 1'b1;
      col_ok <= 1'b1;
      pre_ok <= 1'b1;
    end else begin
      act_at <= act_nx;
      col_at <= col_nx;
      pre_at <= pre_nx;
      act_ok <= (now_nx >= act_nx);
      col_ok <= (now_nx >= col_nx);
      pre_ok <= (now_nx >= pre_nx);
    end
  end

endmodule

// File: rtl/dbt_violation_monitor.sv
module dbt_violation_monitor
  import dbt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  dbt_cmd_e   cmd,
  input  logic       act_sel,
  input  logic       col_sel,
  input  logic       pre_sel,
  output logic       viol,
  output logic [1:0] viol_type
);

  logic legal;

  always_comb begin
    case (cmd)
      CMD_ACT:        legal = act_sel;
      CMD_RD, CMD_WR: legal = col_sel;
      default:        legal = pre_sel;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol      <= 1'b0;
      viol_type <= 2'd0;
    end else if (cmd_valid && !legal && !viol) begin
      viol      <= 1'b1;
      viol_type <= cmd;
    end
  end

endmodule

// File: rtl/dbt_bank_timing_tracker.sv
module dbt_bank_timing_tracker
  import dbt_pkg::*;
#(
  parameter int NUM_RANKS       = 2,
  parameter int BANK_GROUPS     = 1,
  parameter int BANKS_PER_GROUP = 4,
  parameter int CNT_W           = 32,
  parameter int T_RCD           = 16,
  parameter int T_RAS           = 39,
  parameter int T_RP            = 16,
  parameter int T_RRD_L         = 6,
  parameter int T_RRD_S         = 4,
  parameter int T_CCD_L         = 6,
  parameter int T_CCD_S         = 4,
  parameter int T_RTP           = 9,
  parameter int T_WL            = 12,
  parameter int T_BURST         = 4,
  parameter int T_WR            = 18,
  localparam int RANK_W         = clog2_min1(NUM_RANKS),
  localparam int GRP_W          = clog2_min1(BANK_GROUPS),
  localparam int BANK_W         = clog2_min1(BANKS_PER_GROUP),
  localparam int NUM_BANKS      = NUM_RANKS * BANK_GROUPS * BANKS_PER_GROUP
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_type,
  input  logic [RANK_W-1:0]    cmd_rank,
  input  logic [GRP_W-1:0]     cmd_group,
  input  logic [BANK_W-1:0]    cmd_bank,
  output logic [NUM_BANKS-1:0] act_ok,
  output logic [NUM_BANKS-1:0] col_ok,
  output logic [NUM_BANKS-1:0] pre_ok,
  output logic                 viol,
  output logic [1:0]           viol_type
);

  // With a single group there is no "same group" penalty
  localparam int RRD_NEAR = (BANK_GROUPS > 1) ? T_RRD_L : T_RRD_S;
  localparam int CCD_NEAR = (BANK_GROUPS > 1) ? T_CCD_L : T_CCD_S;
  localparam int T_TRC    = T_RAS + T_RP;
  localparam int T_WRPRE  = T_WL + T_BURST + T_WR;
  localparam int IDX_W    = clog2_min1(NUM_BANKS);
  localparam int PER_RANK = BANK_GROUPS * BANKS_PER_GROUP;

  dbt_cmd_e         cmd;
  logic [CNT_W-1:0] now;
  int               grp_eff;
  int               sel;
  logic             in_range;
  logic [IDX_W-1:0] sel_idx;
  logic             act_sel, col_sel, pre_sel;

  assign cmd = dbt_cmd_e'(cmd_type);

  always_comb begin
    grp_eff  = (BANK_GROUPS > 1) ? int'(cmd_group) : 0;
    sel      = (int'(cmd_rank) * BANK_GROUPS + grp_eff) * BANKS_PER_GROUP + int'(cmd_bank);
    in_range = (sel < NUM_BANKS);
    sel_idx  = IDX_W'(sel);
  end

  dbt_cycle_counter #(.CNT_W(CNT_W)) u_counter (
    .clk (clk),
    .rst (rst),
    .now (now)
  );

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_slot
    localparam int SR = i / PER_RANK;
    localparam int SG = (i / BANKS_PER_GROUP) % BANK_GROUPS;
    localparam int SB = i % BANKS_PER_GROUP;

    logic hit, near, own;
    assign hit  = cmd_valid && (int'(cmd_rank) == SR);
    assign near = (grp_eff == SG);
    assign own  = near && (int'(cmd_bank) == SB);

    dbt_bank_slot #(
      .CNT_W    (CNT_W),
      .T_RCD    (T_RCD),
      .T_RAS    (T_RAS),
      .T_RP     (T_RP),
      .T_TRC    (T_TRC),
      .RRD_NEAR (RRD_NEAR),
      .RRD_FAR  (T_RRD_S),
      .CCD_NEAR (CCD_NEAR),
      .CCD_FAR  (T_CCD_S),
      .T_RTP    (T_RTP),
      .T_WRPRE  (T_WRPRE)
    ) u_slot (
      .clk    (clk),
      .rst    (rst),
      .now    (now),
      .hit    (hit),
      .cmd    (cmd),
      .near   (near),
      .own    (own),
      .act_ok (act_ok[i]),
      .col_ok (col_ok[i]),
      .pre_ok (pre_ok[i])
    );
  end

  assign act_sel = in_range ? act_ok[sel_idx] : 1'b1;
  assign col_sel = in_range ? col_ok[sel_idx] : 1'b1;
  assign pre_sel = in_range ? pre_ok[sel_idx] : 1'b1;

  dbt_violation_monitor u_viol (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .act_sel   (act_sel),
    .col_sel   (col_sel),
    .pre_sel   (pre_sel),
    .viol      (viol),
    .viol_type (viol_type)
  );

endmodule

// File: rtl/dbt_bank_timing_tracker_sva.sv
module dbt_bank_timing_tracker_sva
  import dbt_pkg::*;
#(
  parameter int NUM_RANKS       = 2,
  parameter int BANK_GROUPS     = 1,
  parameter int BANKS_PER_GROUP = 4,
  parameter int T_RCD           = 16,
  parameter int T_RAS           = 39,
  parameter int T_RP            = 16,
  parameter int T_RTP           = 9,
  localparam int RANK_W         = clog2_min1(NUM_RANKS),
  localparam int GRP_W          = clog2_min1(BANK_GROUPS),
  localparam int BANK_W         = clog2_min1(BANKS_PER_GROUP),
  localparam int NUM_BANKS      = NUM_RANKS * BANK_GROUPS * BANKS_PER_GROUP
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cmd_valid,
  input logic [1:0]           cmd_type,
  input logic [RANK_W-1:0]    cmd_rank,
  input logic [GRP_W-1:0]     cmd_group,
  input logic [BANK_W-1:0]    cmd_bank,
  input logic [NUM_BANKS-1:0] act_ok,
  input logic [NUM_BANKS-1:0] col_ok,
  input logic [NUM_BANKS-1:0] pre_ok,
  input logic                 viol,
  input logic [1:0]           viol_type
);

  localparam int IDX_W = clog2_min1(NUM_BANKS);

  int               pos;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_d;
  logic             legal;

  always_comb begin
    pos = (int'(cmd_rank) * BANK_GROUPS + ((BANK_GROUPS > 1) ? int'(cmd_group) : 0))
          * BANKS_PER_GROUP + int'(cmd_bank);
    idx = IDX_W'(pos);
    case (cmd_type)
      2'd0:    legal = act_ok[idx];
      2'd3:    legal = pre_ok[idx];
      default: legal = col_ok[idx];
    endcase
  end

  always_ff @(posedge clk) idx_d <= idx;

  // R2: column closed right after an activate when T_RCD spans more than a cycle
  a_r2_col_closed_after_act: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_type == 2'd0 && T_RCD > 1) |=> !col_ok[idx_d]);

  // R3: the activated bank cannot be activated again in the next cycle
  a_r3_own_act_closed: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_type == 2'd0) |=> !act_ok[idx_d]);

  // R5: precharge closed right after a read when T_RTP spans more than a cycle
  a_r5_pre_closed_after_rd: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_type == 2'd1 && T_RTP > 1) |=> !pre_ok[idx_d]);

  // R7: activate closed right after a precharge when T_RP spans more than a cycle
  a_r7_act_closed_after_pre: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_type == 2'd3 && T_RP > 1) |=> !act_ok[idx_d]);

  // R10: too-early command raises the flag
  a_r10_flag_set: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !legal) |=> viol);

  // R10: first offender's type captured
  a_r10_type_captured: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !legal && !viol) |=> (viol_type == $past(cmd_type)));

  // R10: flag and type hold once set
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    viol |=> (viol && $stable(viol_type)));

  // R1: type stays at zero while no violation is recorded
  a_r1_type_idle: assert property (@(posedge clk) disable iff (rst)
    !viol |-> (viol_type == 2'd0));

endmodule

bind dbt_bank_timing_tracker dbt_bank_timing_tracker_sva #(
  .NUM_RANKS       (NUM_RANKS),
  .BANK_GROUPS     (BANK_GROUPS),
  .BANKS_PER_GROUP (BANKS_PER_GROUP),
  .T_RCD           (T_RCD),
  .T_RAS           (T_RAS),
  .T_RP            (T_RP),
  .T_RTP           (T_RTP)
) u_sva (.*);

// File: tb/dbt_bank_timing_tracker_test.sv
module dbt_bank_timing_tracker_test;

  localparam int P_RCD = 3, P_RAS = 6, P_RP = 3;
  localparam int P_RRDL = 4, P_RRDS = 2, P_CCDL = 4, P_CCDS = 2;
  localparam int P_RTP = 2, P_WL = 2, P_BURST = 2, P_WR = 3;

  logic       clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_type = 2'd0;
  logic       cmd_rank = 1'b0, cmd_group = 1'b0, cmd_bank = 1'b0;

  logic [7:0] act_a, col_a, pre_a, act_b, col_b, pre_b;
  logic       viol_a, viol_b;
  logic [1:0] vt_a, vt_b;

  dbt_bank_timing_tracker #(
    .NUM_RANKS(2), .BANK_GROUPS(2), .BANKS_PER_GROUP(2), .CNT_W(32),
    .T_RCD(P_RCD), .T_RAS(P_RAS), .T_RP(P_RP), .T_RRD_L(P_RRDL), .T_RRD_S(P_RRDS),
    .T_CCD_L(P_CCDL), .T_CCD_S(P_CCDS), .T_RTP(P_RTP), .T_WL(P_WL),
    .T_BURST(P_BURST), .T_WR(P_WR)
  ) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_rank(cmd_rank), .cmd_group(cmd_group), .cmd_bank(cmd_bank),
    .act_ok(act_a), .col_ok(col_a), .pre_ok(pre_a), .viol(viol_a), .viol_type(vt_a)
  );

  dbt_bank_timing_tracker #(
    .NUM_RANKS(2), .BANK_GROUPS(1), .BANKS_PER_GROUP(4), .CNT_W(32),
    .T_RCD(P_RCD), .T_RAS(P_RAS), .T_RP(P_RP), .T_RRD_L(P_RRDL), .T_RRD_S(P_RRDS),
    .T_CCD_L(P_CCDL), .T_CCD_S(P_CCDS), .T_RTP(P_RTP), .T_WL(P_WL),
    .T_BURST(P_BURST), .T_WR(P_WR)
  ) uut_flat (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_rank(cmd_rank), .cmd_group(1'b0), .cmd_bank({cmd_group, cmd_bank}),
    .act_ok(act_b), .col_ok(col_b), .pre_ok(pre_b), .viol(viol_b), .viol_type(vt_b)
  );

  int vectors = 0, fails = 0;
  bit done = 1'b0;

  // reference model: earliest legal cycle per bank, two configurations
  int act_at[2][8], col_at[2][8], pre_at[2][8];
  int mnow;
  bit mviol[2];
  int mtype[2];

  function automatic int later(int cur, int cand);
    return (cand > cur) ? cand : cur;
  endfunction

  function automatic int flat_idx(int inst, int r, int g, int b);
    return (inst == 0) ? (r * 2 + g) * 2 + b : r * 4 + g * 2 + b;
  endfunction

  function automatic bit model_legal(int inst, int ty, int idx);
    case (ty)
      0:       return mnow >= act_at[inst][idx];
      3:       return mnow >= pre_at[inst][idx];
      default: return mnow >= col_at[inst][idx];
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      for (int j = 0; j < 8; j++) begin
        act_at[i][j] = 0; col_at[i][j] = 0; pre_at[i][j] = 0;
      end
      mviol[i] = 1'b0; mtype[i] = 0;
    end
    mnow = 0;
  endtask

  task automatic model_apply(int ty, int r, int g, int b);
    for (int inst = 0; inst < 2; inst++) begin
      int tgt;
      tgt = flat_idx(inst, r, g, b);
      if (!model_legal(inst, ty, tgt) && !mviol[inst]) begin
        mviol[inst] = 1'b1; mtype[inst] = ty;
      end
      for (int j = 0; j < 8; j++) begin
        int jr, jg, tg;
        bit own, grouped;
        jr = j / 4;
        jg = (inst == 0) ? (j / 2) % 2 : 0;
        tg = (inst == 0) ? g : 0;
        own = (j == tgt);
        grouped = (inst == 0) && (jg == tg);   // long delay only with real groups
        if (jr != r) continue;
        case (ty)
          0: begin
            if (own) begin
              act_at[inst][j] = later(act_at[inst][j], mnow + P_RAS + P_RP);
              col_at[inst][j] = later(col_at[inst][j], mnow + P_RCD);
              pre_at[inst][j] = later(pre_at[inst][j], mnow + P_RAS);
            end else begin
              act_at[inst][j] = later(act_at[inst][j], mnow + (grouped ? P_RRDL : P_RRDS));
            end
          end
          1, 2: begin
            col_at[inst][j] = later(col_at[inst][j], mnow + (grouped ? P_CCDL : P_CCDS));
            if (own)
              pre_at[inst][j] = later(pre_at[inst][j],
                                      mnow + ((ty == 1) ? P_RTP : P_WL + P_BURST + P_WR));
          end
          default: begin
            if (own) act_at[inst][j] = later(act_at[inst][j], mnow + P_RP);
          end
        endcase
      end
    end
  endtask

  task automatic check_vec(string tag, int inst, logic [7:0] got, logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s inst%0d at cycle %0d: got %b expected %b", tag, inst, mnow, got, exp);
    end
  endtask

  task automatic check_bit(string tag, logic got, logic exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %b expected %b", tag, mnow, got, exp);
    end
  endtask

  task automatic compare_all();
    for (int inst = 0; inst < 2; inst++) begin
      logic [7:0] ea, ec, ep;
      for (int j = 0; j < 8; j++) begin
        ea[j] = (mnow >= act_at[inst][j]);
        ec[j] = (mnow >= col_at[inst][j]);
        ep[j] = (mnow >= pre_at[inst][j]);
      end
      check_vec("R3/R7/R11 act_ok", inst, inst ? act_b : act_a, ea);
      check_vec("R2/R4/R8 col_ok", inst, inst ? col_b : col_a, ec);
      check_vec("R5/R6/R8 pre_ok", inst, inst ? pre_b : pre_a, ep);
      check_vec("R10 viol,type", inst,
                {5'd0, inst ? viol_b : viol_a, inst ? vt_b : vt_a},
                {5'd0, mviol[inst], 2'(mtype[inst])});
    end
  endtask

  task automatic step(bit v, int ty, int r, int g, int b);
    cmd_valid = v;
    cmd_type  = 2'(ty);
    cmd_rank  = 1'(r);
    cmd_group = 1'(g);
    cmd_bank  = 1'(b);
    if (v) model_apply(ty, r, g, b);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    mnow++;
    compare_all();
  endtask

  task automatic idle_until(int t);
    while (mnow < t) step(1'b0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cmd_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    model_reset();
    compare_all();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: got still running expected finished");
      finish_run();
    end
  end

  initial begin
    int t1, t2;
    do_reset();
    // R1 reset state
    check_vec("R1 act_ok after reset", 0, act_a, 8'hFF);
    check_vec("R1 col_ok after reset", 0, col_a, 8'hFF);
    check_vec("R1 pre_ok after reset", 0, pre_a, 8'hFF);
    check_bit("R1 viol after reset", viol_a, 1'b0);
    check_bit("R1 type after reset", vt_a[0] | vt_a[1], 1'b0);

    step(1'b1, 0, 0, 0, 0);                  // ACT r0 g0 b0 at 0
    check_bit("R3 same group neighbour blocked", act_a[1], 1'b0);
    check_bit("R3 other group blocked", act_a[2], 1'b0);
    check_bit("R3 other rank untouched", act_a[4], 1'b1);
    idle_until(2);
    check_bit("R3 other group opens at T_RRD_S", act_a[2], 1'b1);
    check_bit("R3 same group still blocked", act_a[1], 1'b0);
    check_bit("R2 column before T_RCD", col_a[0], 1'b0);
    check_bit("R9 flat copy uses short spacing", act_b[1], 1'b1);
    idle_until(3);
    check_bit("R2 column at T_RCD", col_a[0], 1'b1);
    step(1'b1, 1, 0, 0, 0);                  // RD at 3
    check_bit("R3 same group opens at T_RRD_L", act_a[1], 1'b1);
    idle_until(5);
    check_bit("R8 read does not shorten T_RAS", pre_a[0], 1'b0);
    check_bit("R4 same group column blocked", col_a[1], 1'b0);
    check_bit("R4 other group column open at T_CCD_S", col_a[2], 1'b1);
    check_bit("R4 other rank column untouched", col_a[4], 1'b1);
    idle_until(6);
    check_bit("R2 precharge at T_RAS", pre_a[0], 1'b1);
    idle_until(7);
    check_bit("R4 same group column at T_CCD_L", col_a[1], 1'b1);

    t1 = mnow;                               // rank1 g0 b0 = bit 4
    step(1'b1, 0, 1, 0, 0);
    idle_until(t1 + 5);
    step(1'b1, 1, 1, 0, 0);                  // RD late in the row
    check_bit("R5 precharge held past T_RAS by T_RTP", pre_a[4], 1'b0);
    idle_until(t1 + 7);
    check_bit("R5 precharge at read+T_RTP", pre_a[4], 1'b1);
    step(1'b1, 3, 1, 0, 0);                  // PRE at t1+7
    idle_until(t1 + 9);
    check_bit("R7 activate held by T_RP", act_a[4], 1'b0);
    idle_until(t1 + 10);
    check_bit("R7 activate at precharge+T_RP", act_a[4], 1'b1);

    t2 = mnow;                               // rank1 g1 b0 = bit 6
    step(1'b1, 0, 1, 1, 0);
    idle_until(t2 + 3);
    step(1'b1, 2, 1, 1, 0);                  // WR
    idle_until(t2 + 9);
    check_bit("R6 precharge held by write recovery", pre_a[6], 1'b0);
    idle_until(t2 + 10);
    check_bit("R6 precharge at write+T_WL+T_BURST+T_WR", pre_a[6], 1'b1);

    step(1'b1, 0, 1, 1, 1);                  // ACT rank1 g1 b1
    check_bit("R11 bit 7 is rank1 group1 bank1", act_a[7], 1'b0);
    check_bit("R11 flat bit 7 is rank1 bank3", act_b[7], 1'b0);
    check_bit("R11 bit 3 rank0 untouched", act_a[3], 1'b1);
    step(1'b1, 0, 1, 1, 1);                  // too-early ACT
    check_bit("R10 flag set", viol_a, 1'b1);
    check_bit("R10 flat flag set", viol_b, 1'b1);
    check_vec("R10 type is ACT", 0, {6'd0, vt_a}, 8'd0);
    step(1'b1, 3, 1, 1, 1);                  // too-early PRE
    check_bit("R10 flag sticky", viol_a, 1'b1);
    check_vec("R10 type keeps first", 0, {6'd0, vt_a}, 8'd0);
    idle_until(mnow + 3);
    check_bit("R10 flag still set", viol_a, 1'b1);

    // random legal traffic
    do_reset();
    for (int k = 0; k < 3000; k++) begin
      int ty, r, g, b;
      ty = int'($urandom % 4); r = int'($urandom % 2);
      g = int'($urandom % 2);  b = int'($urandom % 2);
      if (($urandom % 4) != 0 && model_legal(0, ty, flat_idx(0, r, g, b)))
        step(1'b1, ty, r, g, b);
      else
        step(1'b0, 0, 0, 0, 0);
    end
    check_bit("R10 no flag under legal traffic", viol_a, 1'b0);

    // random traffic including too-early commands
    for (int p = 0; p < 3; p++) begin
      do_reset();
      for (int k = 0; k < 500; k++) begin
        if (($urandom % 3) == 0)
          step(1'b1, int'($urandom % 4), int'($urandom % 2),
               int'($urandom % 2), int'($urandom % 2));
        else
          step(1'b0, 0, 0, 0, 0);
      end
    end
    finish_run();
  end

endmodule